// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands over a fixed number of clock cycles using a single double-width product register. A start pulse captures the operands. The multiplicand goes into its own register. The multiplier goes into the lower half of the product register, and the upper half is cleared. Each compute cycle looks at the least significant product bit. When that bit is set, the multiplicand is added into the upper half, and the carry out of that add is kept. In the same cycle the whole register, with the carry above it, moves right by one place. The multiplier bits are used up from the bottom while the finished product grows in from the top.

When the optional signed mode is built in and selected, the operands are converted to magnitudes before the loop starts. A closing cycle then takes the two's complement of the product when exactly one operand was negative. The upper and lower halves of the product register drive the `prod_hi` and `prod_lo` ports directly. A one-cycle `done` pulse marks the end of a run. The ports then hold the result until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: Coming out of reset, `busy` and `done` are low and `prod_hi` and `prod_lo` are both zero.
- R2: A start accepted while idle loads the product register. On the following cycle `prod_hi` reads zero and `prod_lo` holds the multiplier magnitude.
- R3: Each compute cycle does two things at once. If product bit 0 is 1, the multiplicand is added to the upper half, and the carry out becomes the new bit 2*WIDTH-1. In every case the whole register shifts right by one. For WIDTH=4, multiplicand 0010 and multiplier 0011 give the per-cycle values {hi,lo} = 0001_0001, 0001_1000, 0000_1100, 0000_0110.
- R4: If start is sampled at edge k, `busy` is high after edge k and stays high through edge k+WIDTH. `done` is high for exactly the one cycle after edge k+WIDTH+1, and `busy` is low in that cycle.
- R5: In unsigned operation, {prod_hi,prod_lo} equals the full 2*WIDTH-bit unsigned product of the operands. This includes zero, one and both operands all ones.
- R6: With SIGNED_EN=1 and `is_signed` high at start, {prod_hi,prod_lo} equals the two's-complement product of the operands. This includes the most negative value as either or both operands.
- R7: A start pulse while `busy` is high is ignored: the running product and its completion cycle are unchanged.
- R8: After `done`, `prod_hi`, `prod_lo` stay constant and `done` stays low until the next start, whatever the operand inputs do.
- R9: With SIGNED_EN=0, `is_signed` has no effect, and every product is unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| is_signed | input | 1 | Treat operands as two's complement (SIGNED_EN=1 only) |
| mcand | input | WIDTH | Multiplicand, sampled at start |
| mplier | input | WIDTH | Multiplier, sampled at start |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| prod_hi | output | WIDTH | Upper half of the product register |
| prod_lo | output | WIDTH | Lower half of the product register |

## Verification
The product register is wired to the output ports. A wrong add, a lost carry or a misplaced shift therefore shows up on `prod_hi` and `prod_lo` on the clock right after the faulty step. The narrow instance checks its values cycle by cycle. An iteration counter that is off by one shifts `done` by a cycle, and it also leaves the product scaled by a power of two. The result checks and the latency checks both catch this. A sign flag that is captured wrongly only shows in the closing cycle, as a result that is negated when it should not be, or not negated when it should be.

// File: rtl/mul_pkg.sv
package mul_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
   import mul_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic fix,
   output logic busy,
   output logic done
);
   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   mul_state_e      state_q;
   logic [CW-1:0]   cnt_q;
   logic            last;

   assign load = (state_q == ST_IDLE) && start;
   assign step = (state_q == ST_RUN);
   assign fix  = (state_q == ST_FIX);
   assign busy = (state_q != ST_IDLE);
   assign last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_RUN;
               cnt_q   <= '0;
            end
            ST_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (last) state_q <= ST_FIX;
            end
            ST_FIX: begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R4: the count advances by one per compute cycle until the last one
   a_r4_iter_count: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> (step && cnt_q == $past(cnt_q) + 1'b1));

   // R4: done lasts a single cycle
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: a start during a run does not restart the count
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (step && start && !last) |=> (cnt_q != '0));
endmodule

// File: rtl/mul_sign.sv
module mul_sign #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             is_signed,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] mag_a,
   output logic [WIDTH-1:0] mag_b,
   output logic             neg
);
   generate
      if (SIGNED_EN) begin : g_signed
         logic a_neg, b_neg;
         assign a_neg = is_signed && a[WIDTH-1];
         assign b_neg = is_signed && b[WIDTH-1];
         assign mag_a = a_neg ? (~a + 1'b1) : a;
         assign mag_b = b_neg ? (~b + 1'b1) : b;
         assign neg   = a_neg ^ b_neg;
      end else begin : g_unsigned
         logic unused_sel;
         assign unused_sel = is_signed;
         assign mag_a = a;
         assign mag_b = b;
         assign neg   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               fix,
   input  logic [WIDTH-1:0]   mag_a,
   input  logic [WIDTH-1:0]   mag_b,
   input  logic               neg_in,
   output logic [2*WIDTH-1:0] prod
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic             neg_q;
   logic [WIDTH-1:0] addend;
   logic [WIDTH:0]   upper_sum;

   assign addend    = prod[0] ? mcand_q : '0;
   assign upper_sum = {1'b0, prod[PW-1:WIDTH]} + {1'b0, addend};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         neg_q   <= 1'b0;
         prod    <= '0;
      end else if (load) begin
         mcand_q <= mag_a;
         neg_q   <= neg_in;
         prod    <= {{WIDTH{1'b0}}, mag_b};
      end else if (step) begin
         prod <= {upper_sum, prod[WIDTH-1:1]};
      end else if (fix && neg_q) begin
         prod <= ~prod + 1'b1;
      end
   end

   // R2: a load clears the upper half
   a_r2_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (prod[PW-1:WIDTH] == '0));

   // R3: a step with bit 0 clear is a pure right shift
   a_r3_skip_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !prod[0]) |=> (prod == ($past(prod) >> 1)));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] mcand,
   input  logic [WIDTH-1:0] mplier,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] prod_hi,
   output logic [WIDTH-1:0] prod_lo
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shift_add_mul: WIDTH must be at least 2");
      end
   endgenerate

   logic               load, step, fix;
   logic [WIDTH-1:0]   mag_a, mag_b;
   logic               neg;
   logic [2*WIDTH-1:0] prod;

   mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .fix(fix), .busy(busy), .done(done)
   );

   mul_sign #(.WIDTH(WIDTH), .SIGNED_EN(SIGNED_EN)) u_sign (
      .is_signed(is_signed), .a(mcand), .b(mplier),
      .mag_a(mag_a), .mag_b(mag_b), .neg(neg)
   );

   mul_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .fix(fix),
      .mag_a(mag_a), .mag_b(mag_b), .neg_in(neg), .prod(prod)
   );

   assign prod_hi = prod[2*WIDTH-1:WIDTH];
   assign prod_lo = prod[WIDTH-1:0];

   // R8: outputs hold while idle and no start arrives
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({prod_hi, prod_lo}));

   // R4: done never overlaps busy
   a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, is_signed = 1'b0;
   logic [W-1:0] mcand = '0, mplier = '0;
   logic busy, done;
   logic [W-1:0] prod_hi, prod_lo;

   logic start4 = 1'b0, sgn4 = 1'b0;
   logic [3:0] a4 = '0, b4 = '0;
   logic busy4, done4;
   logic [3:0] hi4, lo4;

   int compared = 0;
   int mismatched = 0;

   always #5 clk = ~clk;

   shift_add_mul #(.WIDTH(W), .SIGNED_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .mcand(mcand), .mplier(mplier), .busy(busy), .done(done),
      .prod_hi(prod_hi), .prod_lo(prod_lo)
   );

   shift_add_mul #(.WIDTH(4), .SIGNED_EN(1'b0)) u_dut4 (
      .clk(clk), .rst_n(rst_n), .start(start4), .is_signed(sgn4),
      .mcand(a4), .mplier(b4), .busy(busy4), .done(done4),
      .prod_hi(hi4), .prod_lo(lo4)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_prod(input logic [W-1:0] a,
                                            input logic [W-1:0] b, input bit s);
      logic signed [63:0] sa, sb;
      if (s) begin
         sa = {{32{a[W-1]}}, a};
         sb = {{32{b[W-1]}}, b};
         return sa * sb;
      end
      return {32'd0, a} * {32'd0, b};
   endfunction

   // runs one product; optional stray start during the run
   task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit s, input string tag, input bit stray);
      int cyc;
      logic [63:0] exp;
      exp = ref_prod(a, b, s);
      @(negedge clk);
      mcand = a; mplier = b; is_signed = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      check(busy === 1'b1, {tag, " R4 busy after start"}, {63'd0, busy}, 64'd1);
      if (!s) check(prod_hi === '0 && prod_lo === b, {tag, " R2 load"},
                    {prod_hi, prod_lo}, {32'd0, b});
      while (done !== 1'b1 && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (stray && cyc == 5) begin
            mcand = 32'h1234_5678; mplier = 32'h0F0F_0F0F; start = 1'b1;
         end
         if (stray && cyc == 6) start = 1'b0;
      end
      start = 1'b0;
      check(cyc == W + 1, {tag, " R4 latency"}, 64'(cyc), 64'(W + 1));
      check(busy === 1'b0, {tag, " R4 idle at done"}, {63'd0, busy}, 64'd0);
      check({prod_hi, prod_lo} === exp, tag, {prod_hi, prod_lo}, exp);
      @(negedge clk);
      check(done === 1'b0, {tag, " R4 done one cycle"}, {63'd0, done}, 64'd0);
   endtask

   task automatic t_reset();
      check(busy === 1'b0 && done === 1'b0, "R1 flags", {62'd0, busy, done}, 64'd0);
      check({prod_hi, prod_lo} === 64'd0, "R1 product", {prod_hi, prod_lo}, 64'd0);
   endtask

   task automatic t_trace4();
      logic [7:0] exp_seq [4];
      exp_seq[0] = 8'b0001_0001; exp_seq[1] = 8'b0001_1000;
      exp_seq[2] = 8'b0000_1100; exp_seq[3] = 8'b0000_0110;
      @(negedge clk);
      a4 = 4'b0010; b4 = 4'b0011; start4 = 1'b1;
      @(negedge clk);
      start4 = 1'b0;
      check({hi4, lo4} === 8'b0000_0011, "R2 narrow load", {56'd0, hi4, lo4}, 64'h03);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check({hi4, lo4} === exp_seq[i], "R3 narrow step", {56'd0, hi4, lo4},
               {56'd0, exp_seq[i]});
      end
      @(negedge clk);
      check(done4 === 1'b1 && {hi4, lo4} === 8'h06, "R3 narrow final",
            {55'd0, done4, hi4, lo4}, 64'h106);
   endtask

   task automatic t_unsigned_only4();
      @(negedge clk);
      a4 = 4'hF; b4 = 4'hE; sgn4 = 1'b1; start4 = 1'b1;
      @(negedge clk);
      start4 = 1'b0;
      for (int i = 0; i < 5; i++) @(negedge clk);
      check(done4 === 1'b1 && {hi4, lo4} === 8'd210, "R9 select ignored",
            {55'd0, done4, hi4, lo4}, 64'h1D2);
      sgn4 = 1'b0;
   endtask

   task automatic t_hold();
      logic [63:0] held;
      held = {prod_hi, prod_lo};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         mcand = mcand + 32'h111; mplier = ~mplier; is_signed = ~is_signed;
      end
      check({prod_hi, prod_lo} === held, "R8 hold", {prod_hi, prod_lo}, held);
      check(done === 1'b0, "R8 no done", {63'd0, done}, 64'd0);
   endtask

   initial begin
      #200000;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_trace4();
      t_unsigned_only4();
      run_mul(32'd0, 32'hDEAD_BEEF, 1'b0, "R5 zero", 1'b0);
      run_mul(32'h1, 32'hCAFE_F00D, 1'b0, "R5 one", 1'b0);
      run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5 all ones", 1'b0);
      run_mul(32'h8000_0000, 32'h8000_0000, 1'b1, "R6 min x min", 1'b0);
      run_mul(32'h8000_0000, 32'h1, 1'b1, "R6 min x one", 1'b0);
      run_mul(32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R6 neg x pos", 1'b0);
      run_mul(32'hFFFF_FFF9, 32'hFFFF_FFFD, 1'b1, "R6 neg x neg", 1'b0);
      run_mul(32'hFFFF_FFFF, 32'h0, 1'b1, "R6 neg x zero", 1'b0);
      run_mul(32'hABCD_0123, 32'h9876_5432, 1'b0, "R7 stray start", 1'b1);
      t_hold();
      for (int i = 0; i < 12; i++) begin
         logic [W-1:0] ra, rb;
         ra = $urandom; rb = $urandom;
         run_mul(ra, rb, 1'(i % 2), (i % 2) ? "R6 random" : "R5 random", 1'b0);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule